// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces a pulse-width-modulated signal for dimming a display backlight. It counts cycles of a reference clock through two stages. An 8-bit prescaler divides the clock, and a 16-bit scale counter then counts the divided ticks. A 16-bit compare value sets how many of those ticks in each period the output spends in its active state. Software programs everything through a byte-wide register bus. Each transfer uses a write strobe or a read strobe, an 8-bit address and 8-bit data. The 16-bit quantities are split into low and high bytes at consecutive addresses.

Software updates the registers one byte at a time, so the programmed values may pass through inconsistent intermediate states. To keep such states off the output, the block keeps working copies of the timing values. It refreshes these copies only when a period completes or while the generator is disabled. This means a period is never cut short and never carries a runt pulse. The output can be inverted and gated. It reaches its pad only when the pad's 2-bit function field selects the special function. In every other case the pad passes the ordinary GPIO value and output enable through.

Top module: `bl_pwm_top`

## Requirements
- R1: With the enable bit set, one output period lasts D × (S + 1) reference-clock cycles. S is the 16-bit scale (low byte at 0xA1, high byte at 0xA2). D is the 8-bit divider at 0xA0.
- R2: Each period holds the output active for D × min(B, S + 1) cycles. B is the 16-bit compare value (low byte at 0xA3, high byte at 0xA4). B = 0 gives no active cycles, and B ≥ S + 1 keeps the output active for the whole period.
- R3: A divider value of 0 behaves as a divider of 1.
- R4: Each of the registers 0xA0 to 0xA6 reads back the last byte written to it. Only bits 1:0 of 0xA5 are stored, and its upper bits read 0. Any other address reads 0. Read data appears on the cycle after the clock edge that samples the read strobe.
- R5: In byte 0xA5, bit 1 enables the generator and bit 0 inverts the output. While bit 1 is clear, the output holds the inactive level: low, or high when bit 0 is set. The output takes this level one cycle after the enable bit clears.
- R6: The divider, scale and compare values that are in use are reloaded from the registers only at the end of a period, or continuously while the generator is disabled. Writes made in the middle of a period do not change that period.
- R7: Register 0xA6 holds one 2-bit function field per pad, with pad i at bits 2i+1:2i. Pad 3 drives the PWM output with its enable forced to 1 only when its field is 2'b10. Every other code on pad 3, and every code on pads 0 to 2, passes gpio_out and gpio_oe through to the pad.
- R8: While rst_n is low, pad 3 is not driven: its output enable and output value are both 0. After reset, all PWM registers are 0 and all function fields select GPIO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| gpio_out | input | 4 | GPIO output values for the four pads |
| gpio_oe | input | 4 | GPIO output enables for the four pads |
| pad_out | output | 4 | Pad output values after the function mux |
| pad_oe | output | 4 | Pad output enables after the function mux |

## Verification
The assertions check the local, cycle-by-cycle rules on every clock: the inactive level while disabled, the constant output when the compare value is 0 or at least the full scale, the working values holding steady between period boundaries, the pad 3 routing, the quiet pad during reset, and zero read data for unmapped addresses. Some behaviours span a whole period or depend on the order of writes. These are the exact period length, the number of active cycles, a divider of zero, and a mid-period write that must not affect the period in progress. Only the bench scenarios can show them, by comparing against a behavioural model that counts cycles.

// File: rtl/bl_pwm_pkg.sv
// Package: shared addresses, codes and types for the backlight PWM block.
// Assumes a byte-wide register bus with 8-bit addresses.
package bl_pwm_pkg;
    localparam int PRE_W = 8;
    localparam int SCL_W = 16;

    localparam logic [7:0] ADDR_PRE    = 8'hA0;
    localparam logic [7:0] ADDR_SCL_LO = 8'hA1;
    localparam logic [7:0] ADDR_SCL_HI = 8'hA2;
    localparam logic [7:0] ADDR_CMP_LO = 8'hA3;
    localparam logic [7:0] ADDR_CMP_HI = 8'hA4;
    localparam logic [7:0] ADDR_CTRL   = 8'hA5;
    localparam logic [7:0] ADDR_MUX    = 8'hA6;

    localparam int CTRL_EN_BIT  = 1;
    localparam int CTRL_INV_BIT = 0;

    localparam logic [1:0] FUNC_SPECIAL = 2'b10;

    typedef struct packed {
        logic [SCL_W-1:0] cmp;
        logic [SCL_W-1:0] scale;
        logic [PRE_W-1:0] pre;
    } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
// Module: byte-addressed register file for the PWM timing, control and pad
// function fields. Assumes one access per cycle; read data is registered.
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [7:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    output pwm_cfg_t              cfg,
    output logic                  en,
    output logic                  inv,
    output logic [2*NUM_PINS-1:0] func_sel
);
    localparam int MUX_BYTES = (2 * NUM_PINS + 7) / 8;

    logic [PRE_W-1:0]       pre_q;
    logic [SCL_W-1:0]       scl_q;
    logic [SCL_W-1:0]       cmp_q;
    logic [1:0]             ctrl_q;
    logic [8*MUX_BYTES-1:0] mux_q;
    logic [7:0]             rd_next;

    // Store bytes written to the timing and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            scl_q  <= '0;
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_PRE:    pre_q        <= reg_wdata;
                ADDR_SCL_LO: scl_q[7:0]   <= reg_wdata;
                ADDR_SCL_HI: scl_q[15:8]  <= reg_wdata;
                ADDR_CMP_LO: cmp_q[7:0]   <= reg_wdata;
                ADDR_CMP_HI: cmp_q[15:8]  <= reg_wdata;
                ADDR_CTRL:   ctrl_q       <= reg_wdata[1:0];
                default:     ;
            endcase
        end
    end

    // Store the pad function bytes, one per four pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q <= '0;
        end else if (reg_wr) begin
            for (int j = 0; j < MUX_BYTES; j++) begin
                if (reg_addr == ADDR_MUX + 8'(j))
                    mux_q[8*j +: 8] <= reg_wdata;
            end
        end
    end

    // Select the byte addressed by a read; unmapped addresses give zero.
    always_comb begin
        rd_next = '0;
        case (reg_addr)
            ADDR_PRE:    rd_next = pre_q;
            ADDR_SCL_LO: rd_next = scl_q[7:0];
            ADDR_SCL_HI: rd_next = scl_q[15:8];
            ADDR_CMP_LO: rd_next = cmp_q[7:0];
            ADDR_CMP_HI: rd_next = cmp_q[15:8];
            ADDR_CTRL:   rd_next = {6'b0, ctrl_q};
            default:     ;
        endcase
        for (int j = 0; j < MUX_BYTES; j++) begin
            if (reg_addr == ADDR_MUX + 8'(j))
                rd_next = mux_q[8*j +: 8];
        end
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_next;
    end

    assign cfg.pre   = pre_q;
    assign cfg.scale = scl_q;
    assign cfg.cmp   = cmp_q;
    assign en        = ctrl_q[CTRL_EN_BIT];
    assign inv       = ctrl_q[CTRL_INV_BIT];
    assign func_sel  = mux_q[2*NUM_PINS-1:0];
endmodule

// File: rtl/bl_pwm_core.sv
// Module: two-stage PWM counter with shadowed timing values and a registered
// output. Assumes cfg may change at any cycle; it is sampled only at period
// ends or while disabled.
module bl_pwm_core
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     inv,
    input  pwm_cfg_t cfg,
    output logic     pwm_q,
    output logic     period_end,
    output pwm_cfg_t sh_cfg
);
    logic [PRE_W-1:0] pre_cnt;
    logic [SCL_W-1:0] scl_cnt;
    logic [PRE_W-1:0] div_eff;
    logic             pre_last;
    logic             scl_last;
    logic             active;

    // Effective divider and the tick / period boundary terms.
    always_comb begin
        div_eff    = (sh_cfg.pre == '0) ? PRE_W'(1) : sh_cfg.pre;
        pre_last   = (pre_cnt == div_eff - PRE_W'(1));
        scl_last   = (scl_cnt == sh_cfg.scale);
        period_end = en && pre_last && scl_last;
        active     = (scl_cnt < sh_cfg.cmp);
    end

    // Advance the prescaler and scale counters, clearing them while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_cnt <= '0;
            scl_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            scl_cnt <= scl_last ? '0 : scl_cnt + SCL_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // Reload the working timing values at a period end or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_cfg <= '0;
        else if (!en || period_end)
            sh_cfg <= cfg;
    end

    // Register the polarity-adjusted output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_q <= 1'b0;
        else
            pwm_q <= inv ^ (en & active);
    end
endmodule

// File: rtl/bl_pwm_pinmux.sv
// Module: per-pad function mux. Only pad PWM_PIN has a special function (the
// PWM output); every other pad always passes its GPIO value and enable.
module bl_pwm_pinmux
    import bl_pwm_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PWM_PIN  = 3
) (
    input  logic                  rst_n,
    input  logic [2*NUM_PINS-1:0] func_sel,
    input  logic                  pwm,
    input  logic [NUM_PINS-1:0]   gpio_out,
    input  logic [NUM_PINS-1:0]   gpio_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        if (i == PWM_PIN) begin : g_pwm_pad
            logic special;
            // Route the PWM when selected; keep the pad quiet during reset.
            always_comb begin
                special = (func_sel[2*i +: 2] == FUNC_SPECIAL);
                if (!rst_n) begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = 1'b0;
                end else if (special) begin
                    pad_out[i] = pwm;
                    pad_oe[i]  = 1'b1;
                end else begin
                    pad_out[i] = gpio_out[i];
                    pad_oe[i]  = gpio_oe[i];
                end
            end
        end else begin : g_gpio_pad
            // Plain GPIO pass-through; the field has no effect here.
            assign pad_out[i] = gpio_out[i];
            assign pad_oe[i]  = gpio_oe[i];
        end
    end
endmodule

// File: rtl/bl_pwm_top.sv
// Module: backlight PWM generator top. Connects the register file, the
// counter core and the pad mux. Assumes a single clock and synchronous reset.
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PWM_PIN  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    pwm_cfg_t              cfg;
    pwm_cfg_t              sh_cfg;
    logic                  en;
    logic                  inv;
    logic                  pwm_q;
    logic                  period_end;
    logic [2*NUM_PINS-1:0] func_sel;

    bl_pwm_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .en        (en),
        .inv       (inv),
        .func_sel  (func_sel)
    );

    bl_pwm_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .inv        (inv),
        .cfg        (cfg),
        .pwm_q      (pwm_q),
        .period_end (period_end),
        .sh_cfg     (sh_cfg)
    );

    bl_pwm_pinmux #(.NUM_PINS(NUM_PINS), .PWM_PIN(PWM_PIN)) u_pinmux (
        .rst_n    (rst_n),
        .func_sel (func_sel),
        .pwm      (pwm_q),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
// Module: property checker for bl_pwm_top, attached by the bind below.
module bl_pwm_chk
    import bl_pwm_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PWM_PIN  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_rd,
    input logic [7:0]            reg_addr,
    input logic [7:0]            reg_rdata,
    input logic                  en,
    input logic                  inv,
    input logic                  pwm_q,
    input logic                  period_end,
    input pwm_cfg_t              sh_cfg,
    input logic [2*NUM_PINS-1:0] func_sel,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe
);
    localparam int MUX_BYTES = (2 * NUM_PINS + 7) / 8;
    localparam logic [7:0] LAST_ADDR = ADDR_MUX + 8'(MUX_BYTES - 1);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (pad_oe[PWM_PIN] == 1'b0 && pad_out[PWM_PIN] == 1'b0)); // R8

    AST_DISABLED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pwm_q == $past(inv))); // R5

    AST_CMP_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sh_cfg.cmp == '0) |=> (pwm_q == $past(inv))); // R2

    AST_CMP_FULL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && {1'b0, sh_cfg.cmp} > {1'b0, sh_cfg.scale}) |=> (pwm_q == !$past(inv))); // R2

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !period_end) |=> $stable(sh_cfg)); // R6

    AST_PAD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel[2*PWM_PIN +: 2] == FUNC_SPECIAL) |->
            (pad_out[PWM_PIN] == pwm_q && pad_oe[PWM_PIN] == 1'b1)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr < ADDR_PRE || reg_addr > LAST_ADDR)) |=> (reg_rdata == 8'h00)); // R4
endmodule

bind bl_pwm_top bl_pwm_chk #(.NUM_PINS(NUM_PINS), .PWM_PIN(PWM_PIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .en         (en),
    .inv        (inv),
    .pwm_q      (pwm_q),
    .period_end (period_end),
    .sh_cfg     (sh_cfg),
    .func_sel   (func_sel),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/tb_bl_pwm_top.sv
module tb_bl_pwm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [3:0] gpio_out = 4'hA;
    logic [3:0] gpio_oe = 4'hF;
    wire  [7:0] reg_rdata;
    wire  [3:0] pad_out;
    wire  [3:0] pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bl_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: register mirror, working copies and a position
    // within the period counted in reference cycles.
    logic [7:0] m_pre, m_slo, m_shi, m_blo, m_bhi, m_ctrl, m_mux;
    int  sp, ss, sb, t;
    logic m_out;

    always @(posedge clk) begin
        int pd;
        if (!rst_n) begin
            m_pre = 0; m_slo = 0; m_shi = 0; m_blo = 0; m_bhi = 0;
            m_ctrl = 0; m_mux = 0; sp = 0; ss = 0; sb = 0; t = 0; m_out = 1'b0;
        end else begin
            pd = (sp == 0) ? 1 : sp;
            m_out = m_ctrl[0] ^ (m_ctrl[1] && (t < pd * sb));
            if (m_ctrl[1]) begin
                t++;
                if (t == pd * (ss + 1)) begin
                    t = 0;
                    sp = m_pre; ss = {m_shi, m_slo}; sb = {m_bhi, m_blo};
                end
            end else begin
                t = 0;
                sp = m_pre; ss = {m_shi, m_slo}; sb = {m_bhi, m_blo};
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'hA0: m_pre  = reg_wdata;
                    8'hA1: m_slo  = reg_wdata;
                    8'hA2: m_shi  = reg_wdata;
                    8'hA3: m_blo  = reg_wdata;
                    8'hA4: m_bhi  = reg_wdata;
                    8'hA5: m_ctrl = reg_wdata & 8'h03;
                    8'hA6: m_mux  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Compare every pad against the model on each clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                if (i == 3 && m_mux[7:6] == 2'b10) begin
                    chk("R1/R2/R6 pad3 vs model", pad_out[3], m_out);
                    chk("R7 pad3 oe special", pad_oe[3], 1);
                end else begin
                    chk("R7 gpio out pass", pad_out[i], gpio_out[i]);
                    chk("R7 gpio oe pass", pad_oe[i], gpio_oe[i]);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_rise();
        logic prev;
        int guard;
        prev = pad_out[3];
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
            if (!prev && pad_out[3]) break;
            prev = pad_out[3];
        end while (guard < 2000);
    endtask

    task automatic measure_period(input int exp, input string tag);
        logic prev;
        int n;
        wait_rise();
        prev = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!prev && pad_out[3]) break;
            prev = pad_out[3];
        end while (n < 2000);
        chk(tag, n, exp);
    endtask

    task automatic count_high(input int cycles, input int exp, input string tag);
        int c;
        c = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pad_out[3]) c++;
        end
        chk(tag, c, exp);
    endtask

    task automatic high_run(output int run);
        run = 0;
        while (pad_out[3] && run < 2000) begin
            run++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int run;
        // R8: pad 3 quiet during reset even with GPIO enabled
        repeat (3) @(negedge clk);
        chk("R8 pad3 oe in reset", pad_oe[3], 0);
        chk("R8 pad3 out in reset", pad_out[3], 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 8'hA0; a <= 8'hA6; a++) rd(8'(a), 0, "R8 reset value");

        // R4: readback, control masking, unmapped addresses
        wr(8'hA0, 8'h5A); rd(8'hA0, 8'h5A, "R4 divider readback");
        wr(8'hA1, 8'h34); rd(8'hA1, 8'h34, "R4 scale lo readback");
        wr(8'hA2, 8'h12); rd(8'hA2, 8'h12, "R4 scale hi readback");
        wr(8'hA3, 8'h78); rd(8'hA3, 8'h78, "R4 cmp lo readback");
        wr(8'hA4, 8'h56); rd(8'hA4, 8'h56, "R4 cmp hi readback");
        wr(8'hA5, 8'hFC); rd(8'hA5, 8'h00, "R4 ctrl upper bits");
        wr(8'hA6, 8'h3C); rd(8'hA6, 8'h3C, "R4 mux readback");
        rd(8'h10, 0, "R4 unmapped low");
        rd(8'hA7, 0, "R4 unmapped high");

        // R1/R2: divider 2, scale 4, compare 2 -> period 10, 4 active
        wr(8'hA0, 8'd2); wr(8'hA1, 8'd4); wr(8'hA2, 8'd0);
        wr(8'hA3, 8'd2); wr(8'hA4, 8'd0);
        wr(8'hA6, 8'h80); wr(8'hA5, 8'h02);
        repeat (12) @(negedge clk);
        measure_period(10, "R1 period 2x5");
        count_high(30, 12, "R2 active cycles 3 periods");

        // R6: a compare write during an active run leaves that period intact
        wait_rise();
        reg_wr = 1'b1; reg_addr = 8'hA3; reg_wdata = 8'd3;
        @(negedge clk);
        reg_wr = 1'b0;
        high_run(run);
        chk("R6 run after mid-period write", run + 1, 4);
        wait_rise();
        high_run(run);
        chk("R6 run in next period", run, 6);

        // R5: invert, then disable with and without invert
        wr(8'hA5, 8'h03);
        repeat (12) @(negedge clk);
        count_high(30, 12, "R5 inverted active cycles");
        wr(8'hA5, 8'h01);
        @(negedge clk);
        count_high(20, 20, "R5 disabled inverted level");
        wr(8'hA5, 8'h00);
        @(negedge clk);
        count_high(20, 0, "R5 disabled normal level");

        // R2: compare 0 and compare above scale
        wr(8'hA3, 8'd0); wr(8'hA5, 8'h02);
        repeat (12) @(negedge clk);
        count_high(30, 0, "R2 compare zero");
        wr(8'hA3, 8'd6);
        repeat (12) @(negedge clk);
        count_high(30, 30, "R2 compare over scale");

        // R3: divider 0 acts as 1; scale 3, compare 1 -> period 4, 1 active
        wr(8'hA5, 8'h00);
        wr(8'hA0, 8'd0); wr(8'hA1, 8'd3); wr(8'hA3, 8'd1);
        wr(8'hA5, 8'h02);
        repeat (3) @(negedge clk);
        measure_period(4, "R3 divider zero period");
        count_high(20, 5, "R3 divider zero active");

        // R1: two-byte scale update through an intermediate value (model checks)
        wr(8'hA2, 8'd1); wr(8'hA1, 8'd0);
        repeat (300) @(negedge clk);
        wr(8'hA2, 8'd0); wr(8'hA1, 8'd3);
        repeat (300) @(negedge clk);

        // R7: other codes on pad 3 and special codes on pads 0-2 give GPIO
        wr(8'hA6, 8'h40);
        @(negedge clk);
        chk("R7 code 01 pad3 out", pad_out[3], gpio_out[3]);
        gpio_out = 4'h5; gpio_oe = 4'h0;
        @(negedge clk);
        chk("R7 code 01 pad3 oe", pad_oe[3], 0);
        wr(8'hA6, 8'h2A);
        @(negedge clk);
        chk("R7 pads 0-2 special ignored", pad_out, 4'h5);
        chk("R7 pads 0-2 oe", pad_oe, 4'h0);
        wr(8'hA6, 8'h80);
        @(negedge clk);
        chk("R7 pad3 special oe", pad_oe[3], 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule